// File: doc/BRIEF.md
# Driver Overcurrent Deglitch and Retry Supervisor

This block watches four low-side driver channels and decides, cycle by cycle, which channel's gate drive may run. Each channel brings in a current-limit flag from its analog sense. A flag that stays high for a full deglitch window locks that channel off. The lockout lasts for a fixed retry interval, and then the channel is released on its own. If the short is still there, the channel goes through a new deglitch window and trips again, so a persistent short is retried at a regular rate.

Three conditions act on all channels together.

- A thermal flag turns off every channel and reports a fault until the flag drops. It does not clear any latch.
- An undervoltage flag turns off every channel and holds all channel logic at its idle state.
- A logic-reset input clears every latch and timer at once.

The block drives an active-low fault line. It also drives a step-block line that tells the indexer to ignore step edges. Every window is counted in system-clock cycles. The cycle counts are derived from the clock rate and from the times given as parameters.

Each channel runs its own state machine with three states:

- **CH_ARMED**: the channel is idle and may drive.
- **CH_FILTER**: the flag is high and the deglitch count is running.
- **CH_TRIPPED**: the channel is latched off and the retry count is running.

Channel transitions:

- **ARMED→FILTER**: the flag is sampled high.
- **FILTER→ARMED**: the flag drops before the count expires. The count restarts from zero.
- **FILTER→TRIPPED**: the flag has been high on DEG consecutive samples.
- **TRIPPED→ARMED**: RETRY cycles have elapsed.
- **any→ARMED**: reset or undervoltage is sampled.

The global mode machine has four states, each selected by the sampled inputs with fixed priority:

| State | Selected when |
|---|---|
| SYS_BROWNOUT | undervoltage is high |
| SYS_HOT | thermal is high and undervoltage is low |
| SYS_HELD | reset is high and neither flag above is high |
| SYS_RUN | none of the three inputs is high |

The mode moves from any state to any other in one cycle, following that priority.

Top module: `ocp_retry_supervisor`

## Requirements
- R1: A channel whose current-limit flag is sampled high on DEG consecutive rising clock edges enters the tripped state at the DEG-th edge. Its `ch_enable` bit is 0 from then on and `fault_n` is 0. After DEG-1 such edges the channel is still enabled.
- R2: If a channel's flag is sampled low before the DEG-th consecutive high sample, the count restarts from zero. A run of DEG-1 highs, then one low, then DEG-1 highs does not trip the channel.
- R3: A tripped channel stays disabled for exactly RETRY clock edges. It re-enables at the RETRY-th edge after the trip, and `fault_n` returns to 1 if no other fault is present.
- R4: `fault_n` is 0 whenever any channel is tripped, or when the thermal flag was high at the last edge and undervoltage was low. Otherwise it is 1.
- R5: A high `logic_rst` sampled at an edge clears every trip latch and counter at that edge. While it is held, every `ch_enable` bit is 0 and `step_block` is 1. One edge after it drops, all channels are enabled again without waiting for the retry interval.
- R6: While the thermal flag is sampled high, all `ch_enable` bits are 0, `step_block` is 1 and `fault_n` is 0. One edge after the flag drops, operation resumes.
- R7: A sampled-high undervoltage flag disables all channels and clears all trip latches. `fault_n` is not pulled low by undervoltage alone. This also holds when thermal is high at the same time: undervoltage takes precedence.
- R8: If a channel's flag stays high through the retry expiry, the channel is enabled for exactly DEG cycles while a new deglitch window runs, and then it trips again.
- R9: A trip on one channel leaves the `ch_enable` bits of the other channels at 1. `ch_enable` bit i belongs to channel i.
- R10: `step_block` is 1 whenever any channel is tripped or the mode is not SYS_RUN, and 0 otherwise.
- R11: After `rst_n` is released with all flags low, all `ch_enable` bits are 1, `fault_n` is 1 and `step_block` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| logic_rst | input | 1 | Synchronous logic reset, active high; clears all latches |
| ilim_flag | input | NUM_CH | Per-channel current-limit flag, active high |
| therm_flag | input | 1 | Thermal shutdown flag, active high |
| uv_flag | input | 1 | Supply undervoltage flag, active high |
| ch_enable | output | NUM_CH | Per-channel gate-drive permission, 1 = may drive |
| fault_n | output | 1 | Fault indication, active low |
| step_block | output | 1 | Tells the indexer to ignore step edges, active high |

## Verification
The assertions assume that the flags are already synchronous to `clk`, and that DEG is at least 2 and RETRY is at least 1. They also assume that a trip is only ever caused by the flag being seen high, never by a metastable sample. The bench changes every input half a cycle away from the sampling edge, so each flag value is seen for a whole number of edges. The bench uses a scaled deglitch count of 4 and a retry count of 20, which keeps the retry windows short while still exercising every counter boundary.

// File: rtl/ocp_sup_pkg.sv
package ocp_sup_pkg;

    typedef enum logic [1:0] {
        CH_ARMED   = 2'd0,
        CH_FILTER  = 2'd1,
        CH_TRIPPED = 2'd2
    } chan_state_t;

    typedef enum logic [1:0] {
        SYS_RUN      = 2'd0,
        SYS_HOT      = 2'd1,
        SYS_BROWNOUT = 2'd2,
        SYS_HELD     = 2'd3
    } sys_mode_t;

endpackage

// File: rtl/ocp_chan_fsm.sv
module ocp_chan_fsm
    import ocp_sup_pkg::*;
#(
    parameter int DEG_CYC   = 875,
    parameter int RETRY_CYC = 300000,
    localparam int MAX_CYC  = (DEG_CYC > RETRY_CYC) ? DEG_CYC : RETRY_CYC,
    localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic ilim_i,
    output logic tripped_o
);

    localparam logic [CNT_W-1:0] DEG_LAST   = CNT_W'(DEG_CYC - 1);
    localparam logic [CNT_W-1:0] RETRY_LAST = CNT_W'(RETRY_CYC - 1);

    chan_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr_i) begin
            state_d = CH_ARMED;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                CH_ARMED: begin
                    if (ilim_i) begin
                        state_d = CH_FILTER;
                        cnt_d   = CNT_W'(1);
                    end
                end
                CH_FILTER: begin
                    if (!ilim_i) begin
                        state_d = CH_ARMED;
                        cnt_d   = '0;
                    end else if (cnt_q == DEG_LAST) begin
                        state_d = CH_TRIPPED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                CH_TRIPPED: begin
                    if (cnt_q == RETRY_LAST) begin
                        state_d = CH_ARMED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = CH_ARMED;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        tripped_o = (state_q == CH_TRIPPED);
    end

    // Independent observers for the assertions below.
    logic [CNT_W-1:0] high_run_q;
    logic [CNT_W-1:0] off_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_run_q <= '0;
            off_run_q  <= '0;
        end else begin
            if (!ilim_i || clr_i)
                high_run_q <= '0;
            else if (high_run_q != CNT_W'(MAX_CYC))
                high_run_q <= high_run_q + 1'b1;
            if (tripped_o && !clr_i)
                off_run_q <= off_run_q + 1'b1;
            else
                off_run_q <= '0;
        end
    end

    AST_TRIP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tripped_o) |-> (high_run_q >= CNT_W'(DEG_CYC))) else $error("trip without full run"); // R1

    AST_SHORT_RUN_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_FILTER && !ilim_i) |=> !tripped_o) else $error("short run tripped"); // R2

    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tripped_o |-> (off_run_q < CNT_W'(RETRY_CYC))) else $error("retry overran"); // R3

    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !tripped_o) else $error("clear left latch"); // R5

endmodule

// File: rtl/sup_mode_fsm.sv
module sup_mode_fsm
    import ocp_sup_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      logic_rst_i,
    input  logic      therm_i,
    input  logic      uv_i,
    output sys_mode_t mode_o,
    output logic      run_o,
    output logic      hot_o
);

    sys_mode_t mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            SYS_RUN, SYS_HOT, SYS_BROWNOUT, SYS_HELD: begin
                if (uv_i)
                    mode_d = SYS_BROWNOUT;
                else if (therm_i)
                    mode_d = SYS_HOT;
                else if (logic_rst_i)
                    mode_d = SYS_HELD;
                else
                    mode_d = SYS_RUN;
            end
            default: mode_d = SYS_BROWNOUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= SYS_RUN;
        else
            mode_q <= mode_d;
    end

    always_comb begin
        mode_o = mode_q;
        run_o  = (mode_q == SYS_RUN);
        hot_o  = (mode_q == SYS_HOT);
    end

    AST_UV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> (mode_o == SYS_BROWNOUT)) else $error("undervoltage not dominant"); // R7

    AST_HOT_ENTERED: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_i && !uv_i) |=> hot_o) else $error("thermal mode missed"); // R6

endmodule

// File: rtl/ocp_retry_supervisor.sv
module ocp_retry_supervisor
    import ocp_sup_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CLK_KHZ     = 250000,
    parameter int DEGLITCH_NS = 3500,
    parameter int RETRY_US    = 1200,
    localparam int DEG_CYC    = (CLK_KHZ * DEGLITCH_NS) / 1000000,
    localparam int RETRY_CYC  = (CLK_KHZ * RETRY_US) / 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              logic_rst,
    input  logic [NUM_CH-1:0] ilim_flag,
    input  logic              therm_flag,
    input  logic              uv_flag,
    output logic [NUM_CH-1:0] ch_enable,
    output logic              fault_n,
    output logic              step_block
);

    logic [NUM_CH-1:0] tripped;
    logic              chan_clr;
    sys_mode_t         mode;
    logic              mode_run;
    logic              mode_hot;

    assign chan_clr = logic_rst | uv_flag;

    sup_mode_fsm u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .logic_rst_i (logic_rst),
        .therm_i     (therm_flag),
        .uv_i        (uv_flag),
        .mode_o      (mode),
        .run_o       (mode_run),
        .hot_o       (mode_hot)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        ocp_chan_fsm #(
            .DEG_CYC   (DEG_CYC),
            .RETRY_CYC (RETRY_CYC)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (chan_clr),
            .ilim_i    (ilim_flag[g]),
            .tripped_o (tripped[g])
        );
    end

    always_comb begin
        ch_enable  = ~tripped & {NUM_CH{mode_run}};
        fault_n    = ~((|tripped) | mode_hot);
        step_block = (|tripped) | (mode != SYS_RUN);
    end

    AST_TRIP_FLAGS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (|tripped) |-> (!fault_n && step_block)) else $error("trip not reported"); // R4

    AST_HOT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        therm_flag |=> (ch_enable == '0 && step_block)) else $error("thermal left drive on"); // R6

    AST_UV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (ch_enable == '0 && tripped == '0)) else $error("undervoltage left state"); // R7

    AST_RST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        logic_rst |=> (ch_enable == '0 && step_block)) else $error("reset left drive on"); // R5

endmodule

// File: tb/tb_ocp_retry_supervisor.sv
module tb_ocp_retry_supervisor;

    localparam int NCH = 4;
    localparam int DEG = 4;
    localparam int RET = 20;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           logic_rst = 1'b0;
    logic [NCH-1:0] ilim_flag = '0;
    logic           therm_flag = 1'b0;
    logic           uv_flag = 1'b0;
    logic [NCH-1:0] ch_enable;
    logic           fault_n;
    logic           step_block;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ocp_retry_supervisor #(
        .NUM_CH      (NCH),
        .CLK_KHZ     (1000),
        .DEGLITCH_NS (4000),
        .RETRY_US    (20)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .logic_rst  (logic_rst),
        .ilim_flag  (ilim_flag),
        .therm_flag (therm_flag),
        .uv_flag    (uv_flag),
        .ch_enable  (ch_enable),
        .fault_n    (fault_n),
        .step_block (step_block)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [NCH-1:0] en_exp,
                         input logic fn_exp, input logic sb_exp);
        total++;
        if (ch_enable !== en_exp || fault_n !== fn_exp || step_block !== sb_exp) begin
            bad++;
            $display("FAIL %s: en=%b fault_n=%b step_block=%b expected en=%b fault_n=%b step_block=%b",
                     req, ch_enable, fault_n, step_block, en_exp, fn_exp, sb_exp);
        end
    endtask

    task automatic clean();
        ilim_flag  = '0;
        therm_flag = 1'b0;
        uv_flag    = 1'b0;
        logic_rst  = 1'b1;
        tick(1);
        logic_rst  = 1'b0;
        tick(1);
    endtask

    task automatic t_reset_state();
        check("R11", 4'b1111, 1'b1, 1'b0);
    endtask

    task automatic t_trip_and_retry();
        ilim_flag[0] = 1'b1;
        tick(DEG - 1);
        check("R1", 4'b1111, 1'b1, 1'b0);
        tick(1);
        check("R1", 4'b1110, 1'b0, 1'b1);
        check("R9", 4'b1110, 1'b0, 1'b1);
        ilim_flag[0] = 1'b0;
        tick(RET - 1);
        check("R3", 4'b1110, 1'b0, 1'b1);
        tick(1);
        check("R3", 4'b1111, 1'b1, 1'b0);
        clean();
    endtask

    task automatic t_glitch_reject();
        ilim_flag[1] = 1'b1;
        tick(DEG - 1);
        ilim_flag[1] = 1'b0;
        tick(1);
        ilim_flag[1] = 1'b1;
        tick(DEG - 1);
        check("R2", 4'b1111, 1'b1, 1'b0);
        ilim_flag[1] = 1'b0;
        tick(2);
        check("R2", 4'b1111, 1'b1, 1'b0);
        clean();
    endtask

    task automatic t_persistent();
        ilim_flag[3] = 1'b1;
        tick(DEG);
        check("R8", 4'b0111, 1'b0, 1'b1);
        tick(RET);
        check("R8", 4'b1111, 1'b1, 1'b0);
        tick(DEG - 1);
        check("R8", 4'b1111, 1'b1, 1'b0);
        tick(1);
        check("R8", 4'b0111, 1'b0, 1'b1);
        clean();
    endtask

    task automatic t_logic_reset();
        ilim_flag[2] = 1'b1;
        tick(DEG);
        ilim_flag[2] = 1'b0;
        check("R4", 4'b1011, 1'b0, 1'b1);
        logic_rst = 1'b1;
        tick(1);
        check("R5", 4'b0000, 1'b1, 1'b1);
        check("R10", 4'b0000, 1'b1, 1'b1);
        logic_rst = 1'b0;
        tick(1);
        check("R5", 4'b1111, 1'b1, 1'b0);
        clean();
    endtask

    task automatic t_thermal();
        therm_flag = 1'b1;
        tick(1);
        check("R6", 4'b0000, 1'b0, 1'b1);
        tick(5);
        check("R6", 4'b0000, 1'b0, 1'b1);
        therm_flag = 1'b0;
        tick(1);
        check("R6", 4'b1111, 1'b1, 1'b0);
        clean();
    endtask

    task automatic t_undervoltage();
        ilim_flag[0] = 1'b1;
        tick(DEG);
        ilim_flag[0] = 1'b0;
        check("R4", 4'b1110, 1'b0, 1'b1);
        uv_flag    = 1'b1;
        therm_flag = 1'b1;
        tick(1);
        check("R7", 4'b0000, 1'b1, 1'b1);
        uv_flag    = 1'b0;
        therm_flag = 1'b0;
        tick(1);
        check("R7", 4'b1111, 1'b1, 1'b0);
        clean();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset_state();
        t_trip_and_retry();
        t_glitch_reject();
        t_persistent();
        t_logic_reset();
        t_thermal();
        t_undervoltage();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule